// File: doc/BRIEF.md
# Multicycle Sequencing Controller

This block is the hardwired control unit of a multicycle load/store processor. A small state register steps each instruction through a fetch cycle, a decode cycle and a class-specific run of execute, memory and write-back cycles. After decode and after the address cycle, the 6-bit opcode from the instruction register picks the next state. Five instruction classes are handled: register-to-register arithmetic, word load, word store, branch on equal, and jump.

The next state comes from a two-level array of product terms. Each term matches one state and, when needed, one opcode class, and its next-state code is ORed into the result. All datapath controls are a pure decode of the 4-bit state code, so they change only on clock edges. The state code is also driven out so that a testbench or trace can observe it.

Top module: `mcc_controller`

## Requirements
- R1: A synchronous active-high `rst` puts the controller into state 0 on the next rising edge, including when an instruction is partway through.
- R2: State 0 asserts `pc_load`, `mem_rd_en` and `ir_load`, with `addr_sel`=0 (address from PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant four), `alu_func`=00 (add) and `pc_src`=00 (ALU result). The next state is always 1.
- R3: State 1 drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted sign-extended offset) and `alu_func`=00. It dispatches on the opcode: 100011 (load) and 101011 (store) go to 2, 000000 (register op) goes to 6, 000100 (branch) goes to 8, and 000010 (jump) goes to 9.
- R4: State 2 drives `alu_a_sel`=1 (register A), `alu_b_sel`=10 (sign-extended offset) and `alu_func`=00. The next state is 3 for the load opcode and 5 for the store opcode.
- R5: State 3 asserts `mem_rd_en` with `addr_sel`=1 (address from ALU output register) and moves to 4. State 4 asserts `rf_wr_en` with `rf_dst_sel`=0 (rt field) and `rf_data_sel`=1 (memory data), then moves to 0.
- R6: State 5 asserts `mem_wr_en` with `addr_sel`=1 and moves to 0.
- R7: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_func`=10 (function field decides), then moves to 7. State 7 asserts `rf_wr_en` with `rf_dst_sel`=1 (rd field) and `rf_data_sel`=0 (ALU output register), then moves to 0.
- R8: State 8 asserts `pc_load_cond` with `alu_a_sel`=1, `alu_b_sel`=00, `alu_func`=01 (subtract) and `pc_src`=01 (ALU output register), then moves to 0.
- R9: State 9 asserts `pc_load` with `pc_src`=10 (jump target), then moves to 0.
- R10: An opcode that is not one of the five listed moves the controller from state 1 to 0. In state 2, any opcode other than load or store also moves it to 0.
- R11: Every control not named for a state is driven to 0. `rf_wr_en` is high only in states 4 and 7, and `mem_rd_en` and `mem_wr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state code |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_cond | output | 1 | PC write when the ALU zero flag is set |
| mem_rd_en | output | 1 | Memory read |
| mem_wr_en | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| rf_wr_en | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| rf_data_sel | output | 1 | Write data: 0 ALU output register, 1 memory data |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU second operand select |
| alu_func | output | 2 | ALU operation select |
| pc_src | output | 2 | PC source select |

## Verification
The assertions assume that `opcode` comes from an instruction register that is loaded only during fetch, so its value in state 2 is the one that was decoded in state 1. They also assume that reset is high at the first clock edge, so the state register never holds an undefined code once checking begins. The stimulus keeps the opcode fixed for each instruction's run in every normal sequence. It changes the opcode in state 2 only on purpose, to exercise R10, and it raises reset only after the initial reset has completed.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    parameter int ST_W = 4;
    parameter int OP_W = 6;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_ALUEX  = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRCMP  = 4'd8,
        ST_JMP    = 4'd9
    } mcc_state_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    // opcode class indices (one bit per class in the class vector)
    localparam int CLS_RTYPE = 0;
    localparam int CLS_JUMP  = 1;
    localparam int CLS_BEQ   = 2;
    localparam int CLS_LOAD  = 3;
    localparam int CLS_STORE = 4;
    localparam int CLS_N     = 5;

    typedef logic [CLS_N-1:0] cls_vec_t;

    localparam logic [1:0] BSEL_REG    = 2'b00;
    localparam logic [1:0] BSEL_FOUR   = 2'b01;
    localparam logic [1:0] BSEL_IMM    = 2'b10;
    localparam logic [1:0] BSEL_IMM_SH = 2'b11;

    localparam logic [1:0] FN_ADD   = 2'b00;
    localparam logic [1:0] FN_SUB   = 2'b01;
    localparam logic [1:0] FN_FIELD = 2'b10;

    localparam logic [1:0] PCS_ALU = 2'b00;
    localparam logic [1:0] PCS_REG = 2'b01;
    localparam logic [1:0] PCS_JMP = 2'b10;

    typedef struct packed {
        logic       pc_load;
        logic       pc_load_cond;
        logic       mem_rd_en;
        logic       mem_wr_en;
        logic       ir_load;
        logic       addr_sel;
        logic       rf_wr_en;
        logic       rf_dst_sel;
        logic       rf_data_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_func;
        logic [1:0] pc_src;
    } ctrl_t;

    // one product term of the next-state array
    typedef struct packed {
        logic [ST_W-1:0] cur;
        logic            any_cls;
        cls_vec_t        cls_mask;
        logic [ST_W-1:0] nxt;
    } term_t;

    localparam int N_TERM = 9;

    function automatic cls_vec_t cls_bit(input int k);
        cls_vec_t v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    function automatic logic [OP_W-1:0] class_opcode(input int k);
        case (k)
            CLS_RTYPE: return OPC_RTYPE;
            CLS_JUMP:  return OPC_JUMP;
            CLS_BEQ:   return OPC_BEQ;
            CLS_LOAD:  return OPC_LOAD;
            default:   return OPC_STORE;
        endcase
    endfunction

    function automatic term_t term_cfg(input int i);
        term_t t;
        t = '0;
        case (i)
            0: begin t.cur = ST_FETCH;  t.any_cls = 1'b1;                   t.nxt = ST_DECODE; end
            1: begin t.cur = ST_DECODE; t.cls_mask = cls_bit(CLS_LOAD) | cls_bit(CLS_STORE);
                     t.nxt = ST_ADDR; end
            2: begin t.cur = ST_DECODE; t.cls_mask = cls_bit(CLS_RTYPE);    t.nxt = ST_ALUEX; end
            3: begin t.cur = ST_DECODE; t.cls_mask = cls_bit(CLS_BEQ);      t.nxt = ST_BRCMP; end
            4: begin t.cur = ST_DECODE; t.cls_mask = cls_bit(CLS_JUMP);     t.nxt = ST_JMP;   end
            5: begin t.cur = ST_ADDR;   t.cls_mask = cls_bit(CLS_LOAD);     t.nxt = ST_LDRD;  end
            6: begin t.cur = ST_ADDR;   t.cls_mask = cls_bit(CLS_STORE);    t.nxt = ST_STWR;  end
            7: begin t.cur = ST_LDRD;   t.any_cls = 1'b1;                   t.nxt = ST_LDWB;  end
            default: begin t.cur = ST_ALUEX; t.any_cls = 1'b1;              t.nxt = ST_ALUWB; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output cls_vec_t        cls_o
);
    // one comparator per recognised class; an unknown opcode leaves all zero
    for (genvar k = 0; k < CLS_N; k++) begin : g_cls
        localparam logic [OP_W-1:0] MATCH = class_opcode(k);
        assign cls_o[k] = (opcode == MATCH);
    end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  logic [ST_W-1:0] state,
    input  cls_vec_t        cls,
    output logic [ST_W-1:0] nxt
);
    logic [ST_W-1:0] term_out [N_TERM];

    // AND plane: each term matches a state and optionally a class
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        localparam term_t CFG = term_cfg(t);
        logic hit;
        assign hit         = (state == CFG.cur) && (CFG.any_cls || (|(cls & CFG.cls_mask)));
        assign term_out[t] = hit ? CFG.nxt : '0;
    end

    // OR plane: no matching term yields state 0
    always_comb begin
        nxt = '0;
        for (int t = 0; t < N_TERM; t++) begin
            nxt = nxt | term_out[t];
        end
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  logic [ST_W-1:0] state,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl = '0;
        case (state)
            ST_FETCH: begin
                ctrl.pc_load   = 1'b1;
                ctrl.mem_rd_en = 1'b1;
                ctrl.ir_load   = 1'b1;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_func  = FN_ADD;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = BSEL_IMM_SH;
                ctrl.alu_func  = FN_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_func  = FN_ADD;
            end
            ST_LDRD: begin
                ctrl.mem_rd_en = 1'b1;
                ctrl.addr_sel  = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_wr_en    = 1'b1;
                ctrl.rf_data_sel = 1'b1;
            end
            ST_STWR: begin
                ctrl.mem_wr_en = 1'b1;
                ctrl.addr_sel  = 1'b1;
            end
            ST_ALUEX: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_func  = FN_FIELD;
            end
            ST_ALUWB: begin
                ctrl.rf_wr_en   = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
            end
            ST_BRCMP: begin
                ctrl.pc_load_cond = 1'b1;
                ctrl.alu_a_sel    = 1'b1;
                ctrl.alu_b_sel    = BSEL_REG;
                ctrl.alu_func     = FN_SUB;
                ctrl.pc_src       = PCS_REG;
            end
            ST_JMP: begin
                ctrl.pc_load = 1'b1;
                ctrl.pc_src  = PCS_JMP;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/mcc_controller.sv
module mcc_controller
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic [ST_W-1:0] state_o,
    output logic            pc_load,
    output logic            pc_load_cond,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic            ir_load,
    output logic            addr_sel,
    output logic            rf_wr_en,
    output logic            rf_dst_sel,
    output logic            rf_data_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_func,
    output logic [1:0]      pc_src
);
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;
    cls_vec_t        cls;
    ctrl_t           ctrl;

    mcc_opclass u_opclass (
        .opcode (opcode),
        .cls_o  (cls)
    );

    mcc_next_state u_next (
        .state (state_q),
        .cls   (cls),
        .nxt   (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    mcc_ctrl_decode u_decode (
        .state (state_q),
        .ctrl  (ctrl)
    );

    assign state_o      = state_q;
    assign pc_load      = ctrl.pc_load;
    assign pc_load_cond = ctrl.pc_load_cond;
    assign mem_rd_en    = ctrl.mem_rd_en;
    assign mem_wr_en    = ctrl.mem_wr_en;
    assign ir_load      = ctrl.ir_load;
    assign addr_sel     = ctrl.addr_sel;
    assign rf_wr_en     = ctrl.rf_wr_en;
    assign rf_dst_sel   = ctrl.rf_dst_sel;
    assign rf_data_sel  = ctrl.rf_data_sel;
    assign alu_a_sel    = ctrl.alu_a_sel;
    assign alu_b_sel    = ctrl.alu_b_sel;
    assign alu_func     = ctrl.alu_func;
    assign pc_src       = ctrl.pc_src;
endmodule

// File: rtl/mcc_controller_chk.sv
module mcc_controller_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic [3:0] state_o,
    input logic       pc_load_cond,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       rf_wr_en
);
    logic op_known;
    assign op_known = (opcode == 6'b000000) || (opcode == 6'b000010) || (opcode == 6'b000100)
                   || (opcode == 6'b100011) || (opcode == 6'b101011);

    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1);

    a_r3_load_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && opcode == 6'b100011) |=> state_o == 4'd2);

    a_r5_read_then_write: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd3 |=> state_o == 4'd4);

    a_r7_exec_then_write: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd6 |=> state_o == 4'd7);

    a_r9_terminal_return: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd4 || state_o == 4'd5 || state_o == 4'd7 || state_o == 4'd8 || state_o == 4'd9)
        |=> state_o == 4'd0);

    a_r10_unknown_op: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && !op_known) |=> state_o == 4'd0);

    a_r8_cond_only_branch: assert property (@(posedge clk) disable iff (rst)
        pc_load_cond |-> state_o == 4'd8);

    a_r11_regwrite_states: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (state_o == 4'd4 || state_o == 4'd7));

    a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

bind mcc_controller mcc_controller_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .opcode       (opcode),
    .state_o      (state_o),
    .pc_load_cond (pc_load_cond),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .rf_wr_en     (rf_wr_en)
);

// File: tb/mcc_controller_bench.sv
`timescale 1ns/1ps
module mcc_controller_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic [3:0] state_o;
    logic pc_load, pc_load_cond, mem_rd_en, mem_wr_en, ir_load, addr_sel;
    logic rf_wr_en, rf_dst_sel, rf_data_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_func, pc_src;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [5:0] OP_R = 6'b000000, OP_J = 6'b000010, OP_BEQ = 6'b000100,
                           OP_LW = 6'b100011, OP_SW = 6'b101011, OP_BAD = 6'b111111,
                           OP_BAD2 = 6'b001000;

    typedef struct {
        logic [3:0] st;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    mcc_controller u_mcc_controller (
        .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
        .pc_load(pc_load), .pc_load_cond(pc_load_cond), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .ir_load(ir_load), .addr_sel(addr_sel),
        .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel), .rf_data_sel(rf_data_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_func(alu_func), .pc_src(pc_src)
    );

    // order: pcld pccond rd wr ir addr rfw dst data a b[2] fn[2] pcs[2]
    function automatic logic [15:0] exp_ctrl(input logic [3:0] st);
        logic pl, pc, rd, wr, ir, ad, rw, ds, dt, a;
        logic [1:0] b, fn, ps;
        {pl, pc, rd, wr, ir, ad, rw, ds, dt, a} = '0;
        b = 2'b00; fn = 2'b00; ps = 2'b00;
        case (st)
            4'd0: begin pl = 1; rd = 1; ir = 1; b = 2'b01; end
            4'd1: b = 2'b11;
            4'd2: begin a = 1; b = 2'b10; end
            4'd3: begin rd = 1; ad = 1; end
            4'd4: begin rw = 1; dt = 1; end
            4'd5: begin wr = 1; ad = 1; end
            4'd6: begin a = 1; fn = 2'b10; end
            4'd7: begin rw = 1; ds = 1; end
            4'd8: begin pc = 1; a = 1; fn = 2'b01; ps = 2'b01; end
            4'd9: begin pl = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pl, pc, rd, wr, ir, ad, rw, ds, dt, a, b, fn, ps};
    endfunction

    function automatic logic [15:0] act_ctrl();
        return {pc_load, pc_load_cond, mem_rd_en, mem_wr_en, ir_load, addr_sel, rf_wr_en,
                rf_dst_sel, rf_data_sel, alu_a_sel, alu_b_sel, alu_func, pc_src};
    endfunction

    task automatic check_now(input logic [3:0] st, input string req);
        n_vec++;
        if (state_o !== st) begin
            n_fail++;
            $display("FAIL %s state: actual %0d expected %0d", req, state_o, st);
        end
        n_vec++;
        if (act_ctrl() !== exp_ctrl(st)) begin
            n_fail++;
            $display("FAIL %s controls in state %0d: actual %b expected %b",
                     req, st, act_ctrl(), exp_ctrl(st));
        end
        n_vec++;
        if (rf_wr_en !== (st == 4'd4 || st == 4'd7)) begin
            n_fail++;
            $display("FAIL R11 rf_wr_en in state %0d: actual %b expected %b",
                     st, rf_wr_en, (st == 4'd4 || st == 4'd7));
        end
    endtask

    // monitor: compares each cycle against the scoreboard queue
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_now(e.st, e.req);
        end
    end

    // driver: one call per cycle, sets inputs after the edge and queues the state expected now
    task automatic cyc(input logic r, input logic [5:0] op, input logic [3:0] st, input string req);
        @(posedge clk);
        #1;
        rst    = r;
        opcode = op;
        sb_q.push_back('{st: st, req: req});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now(4'd0, "R1");

        // R4/R5 load: 0 1 2 3 4
        cyc(0, OP_LW, 4'd0, "R2"); cyc(0, OP_LW, 4'd1, "R3"); cyc(0, OP_LW, 4'd2, "R4");
        cyc(0, OP_LW, 4'd3, "R5"); cyc(0, OP_LW, 4'd4, "R5");
        // R6 store: 0 1 2 5
        cyc(0, OP_SW, 4'd0, "R2"); cyc(0, OP_SW, 4'd1, "R3"); cyc(0, OP_SW, 4'd2, "R4");
        cyc(0, OP_SW, 4'd5, "R6");
        // R7 register op: 0 1 6 7
        cyc(0, OP_R, 4'd0, "R2"); cyc(0, OP_R, 4'd1, "R3"); cyc(0, OP_R, 4'd6, "R7");
        cyc(0, OP_R, 4'd7, "R7");
        // R8 branch: 0 1 8
        cyc(0, OP_BEQ, 4'd0, "R2"); cyc(0, OP_BEQ, 4'd1, "R3"); cyc(0, OP_BEQ, 4'd8, "R8");
        // R9 jump: 0 1 9
        cyc(0, OP_J, 4'd0, "R2"); cyc(0, OP_J, 4'd1, "R3"); cyc(0, OP_J, 4'd9, "R9");
        // R10 unknown opcode at decode
        cyc(0, OP_BAD, 4'd0, "R10"); cyc(0, OP_BAD, 4'd1, "R10");
        // R10 opcode altered in address state (unknown, then register op)
        cyc(0, OP_LW, 4'd0, "R10"); cyc(0, OP_LW, 4'd1, "R10"); cyc(0, OP_BAD2, 4'd2, "R10");
        cyc(0, OP_SW, 4'd0, "R10"); cyc(0, OP_SW, 4'd1, "R10"); cyc(0, OP_R, 4'd2, "R10");
        // R1 reset partway through a load
        cyc(0, OP_LW, 4'd0, "R1"); cyc(0, OP_LW, 4'd1, "R1"); cyc(1, OP_LW, 4'd2, "R1");
        cyc(0, OP_LW, 4'd0, "R1"); cyc(0, OP_LW, 4'd1, "R1"); cyc(0, OP_LW, 4'd2, "R1");
        cyc(0, OP_LW, 4'd3, "R5"); cyc(0, OP_LW, 4'd4, "R5");
        // back-to-back branch then jump returns to fetch
        cyc(0, OP_BEQ, 4'd0, "R8"); cyc(0, OP_BEQ, 4'd1, "R8"); cyc(0, OP_BEQ, 4'd8, "R8");
        cyc(0, OP_J, 4'd0, "R9");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule